// File: doc/BRIEF.md
# Fixed-Priority Interrupt Selector

This block collects one-cycle interrupt request pulses from six sources and keeps each one in a sticky pending bit. Each cycle it picks the one pending source to deliver next and presents it as a one-hot grant with a valid flag. The six sources are system reset, machine check, watchdog, external input, fixed-interval timer and decrementer. When the consumer takes the interrupt it pulses an acknowledge, and that clears only the pending bit named by the current grant.

The selection is fixed. Reset and machine check are delivered whatever the external-enable bit holds. The other four sources are asynchronous and are eligible only while that bit is 1. The grant is combinational from the pending registers and the enable bit, so a change of enable shows on the grant in the same cycle.

Source index encoding, used on both `req_i` and `grant_o`:

| Bit | Source |
|-----|--------|
| 0 | reset |
| 1 | machine check |
| 2 | watchdog |
| 3 | external input |
| 4 | fixed-interval timer |
| 5 | decrementer |

Top module: `irq_fixed_selector`

## Requirements
- R1: An active-high synchronous `rst` clears every pending bit, so after reset `valid_o` is 0 and `grant_o` is 0.
- R2: While the reset source (bit 0) is pending, `grant_o` is 6'b000001, whatever else is pending and whatever `ee_i` holds.
- R3: When the machine-check source (bit 1) is pending and reset is not, `grant_o` is 6'b000010, with `ee_i` either 0 or 1.
- R4: Watchdog, external input, fixed-interval timer and decrementer (bits 2 to 5) are never granted while `ee_i` is 0.
- R5: With `ee_i` at 1 and neither bit 0 nor bit 1 pending, the pending asynchronous sources win in this order: watchdog (bit 2), then external input (bit 3), then fixed-interval timer (bit 4), then decrementer (bit 5).
- R6: When no pending source qualifies, `grant_o` is all zero and `valid_o` is 0. Otherwise `valid_o` is 1.
- R7: A one-cycle `req_i` pulse on a bit makes that source pending from the next cycle on. It stays pending across any number of cycles until it is acknowledged.
- R8: `ack_i` clears only the pending bit that `grant_o` names in that cycle. An `ack_i` while `valid_o` is 0 changes no pending bit.
- R9: If a request pulse and a clearing acknowledge hit the same bit in the same cycle, the bit stays pending.
- R10: A change of `ee_i` changes `grant_o` and `valid_o` in the same cycle, with no register in between.
- R11: `grant_o` has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 6 | One-cycle request pulses, one bit per source |
| ee_i | input | 1 | External-enable bit; gates bits 2 to 5 |
| ack_i | input | 1 | Acknowledge of the currently granted source |
| grant_o | output | 6 | One-hot selected source |
| valid_o | output | 1 | A source is selected |

## Verification
A pending bit that is lost, stuck or set wrongly shows on `grant_o` in the cycle right after the edge that corrupted it. It shows either there or at the following acknowledge, when the grant steps to the next source. The directed scenarios therefore fill the pending bank with known sets, drain it one acknowledge at a time and compare each intermediate grant. An ordering or enable-gating fault is visible in the same cycle, with no register delay. The bench toggles `ee_i` mid-cycle and samples at once, which exposes any stray register or latch on that path.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

    localparam int unsigned SRC_N = 6;

    typedef enum logic [2:0] {
        SRC_RST = 3'd0,
        SRC_MCK = 3'd1,
        SRC_WDT = 3'd2,
        SRC_EXT = 3'd3,
        SRC_FIT = 3'd4,
        SRC_DEC = 3'd5
    } src_e;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t onehot;
        logic     valid;
    } pick_t;

    function automatic src_vec_t src_bit(input src_e s);
        return src_vec_t'(1) << s;
    endfunction

    // Sources that are eligible only while the enable bit is set
    localparam src_vec_t GATED_SRCS = src_bit(SRC_WDT) | src_bit(SRC_EXT)
                                    | src_bit(SRC_FIT) | src_bit(SRC_DEC);

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] pend_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[i] <= 1'b0;
            else if (set_i[i])
                pend_q[i] <= 1'b1;
            else if (clr_i[i])
                pend_q[i] <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (pend_o == '0));

    // R7 R9
    set_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // R8
    hold_unless_clr_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_o & ~clr_i) != '0) |=>
            ((pend_o & $past(pend_o & ~clr_i)) == $past(pend_o & ~clr_i)));

endmodule

// File: rtl/irq_en_gate.sv
module irq_en_gate #(
    parameter int unsigned N     = 6,
    parameter logic [N-1:0] GATED = '0
) (
    input  logic [N-1:0] pend_i,
    input  logic         en_i,
    output logic [N-1:0] elig_o
);

    for (genvar i = 0; i < N; i++) begin : g_src
        if (GATED[i]) begin : g_masked
            assign elig_o[i] = pend_i[i] & en_i;
        end else begin : g_direct
            assign elig_o[i] = pend_i[i];
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         valid_o
);

    // taken[i]: some lower-index (higher-priority) source is eligible
    logic [N:0] taken;

    assign taken[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant_o[i]  = req_i[i] & ~taken[i];
        assign taken[i+1]  = taken[i] | req_i[i];
    end

    assign valid_o = taken[N];

endmodule

// File: rtl/irq_fixed_selector.sv
module irq_fixed_selector
    import irqsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] req_i,
    input  logic             ee_i,
    input  logic             ack_i,
    output logic [SRC_N-1:0] grant_o,
    output logic             valid_o
);

    src_vec_t pend;
    src_vec_t elig;
    src_vec_t clr;
    pick_t    pick;

    assign clr = pick.onehot & {SRC_N{ack_i}};

    irq_pend_bank #(.N(SRC_N)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (req_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irq_en_gate #(.N(SRC_N), .GATED(GATED_SRCS)) u_gate (
        .pend_i (pend),
        .en_i   (ee_i),
        .elig_o (elig)
    );

    irq_prio_pick #(.N(SRC_N)) u_pick (
        .req_i   (elig),
        .grant_o (pick.onehot),
        .valid_o (pick.valid)
    );

    assign grant_o = pick.onehot;
    assign valid_o = pick.valid;

    // R11
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R2
    reset_first_chk: assert property (@(posedge clk) disable iff (rst)
        pend[SRC_RST] |-> (grant_o == src_bit(SRC_RST)));

    // R3
    mck_second_chk: assert property (@(posedge clk) disable iff (rst)
        (pend[SRC_MCK] && !pend[SRC_RST]) |-> (grant_o == src_bit(SRC_MCK)));

    // R4
    gated_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ee_i |-> ((grant_o & GATED_SRCS) == '0));

    // R6
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> (!valid_o && grant_o == '0));

endmodule

// File: tb/irq_fixed_selector_tb.sv
module irq_fixed_selector_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] req_i;
    logic       ee_i;
    logic       ack_i;
    logic [5:0] grant_o;
    logic       valid_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [5:0] B_RST = 6'b000001;
    localparam logic [5:0] B_MCK = 6'b000010;
    localparam logic [5:0] B_WDT = 6'b000100;
    localparam logic [5:0] B_EXT = 6'b001000;
    localparam logic [5:0] B_FIT = 6'b010000;
    localparam logic [5:0] B_DEC = 6'b100000;

    always #10 clk = ~clk;

    irq_fixed_selector dut_i (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_i),
        .ee_i    (ee_i),
        .ack_i   (ack_i),
        .grant_o (grant_o),
        .valid_o (valid_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [5:0] eg, input logic ev);
        n_chk++;
        if (grant_o !== eg || valid_o !== ev) begin
            n_fail++;
            $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                     tag, grant_o, valid_o, eg, ev);
        end
    endtask

    task automatic pulse(input logic [5:0] m);
        req_i = m;
        step();
        req_i = '0;
    endtask

    task automatic ack_one();
        ack_i = 1'b1;
        step();
        ack_i = 1'b0;
    endtask

    task automatic drain();
        ee_i = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (valid_o) ack_one();
        end
        chk("R6 drain empty", '0, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_i = '0; ee_i = 1'b0; ack_i = 1'b0;
        step(); step();
        rst = 1'b0;
        chk("R1 after reset", '0, 1'b0);
        ee_i = 1'b1;
        pulse(6'b111111);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1 reset clears pending", '0, 1'b0);
    endtask

    task automatic t_idle();
        ee_i = 1'b1;
        step();
        chk("R6 idle", '0, 1'b0);
        ack_one();
        chk("R8 ack idle harmless", '0, 1'b0);
    endtask

    task automatic t_full_order();
        ee_i = 1'b1;
        pulse(6'b111111);
        chk("R2 reset wins", B_RST, 1'b1);
        ee_i = 1'b0;
        #1 chk("R2 reset wins ee=0", B_RST, 1'b1);
        ee_i = 1'b1;
        ack_one();
        chk("R3 mck second", B_MCK, 1'b1);
        ack_one();
        chk("R5 wdt first async", B_WDT, 1'b1);
        ack_one();
        chk("R5 ext next", B_EXT, 1'b1);
        ack_one();
        chk("R5 fit next", B_FIT, 1'b1);
        ack_one();
        chk("R5 dec last", B_DEC, 1'b1);
        ack_one();
        chk("R6 all drained", '0, 1'b0);
    endtask

    task automatic t_mck_gating();
        ee_i = 1'b0;
        pulse(B_MCK | B_WDT | B_DEC);
        chk("R3 mck with ee=0", B_MCK, 1'b1);
        ack_one();
        chk("R4 async masked", '0, 1'b0);
        ee_i = 1'b1;
        #1 chk("R10 enable same cycle", B_WDT, 1'b1);
        ee_i = 1'b0;
        #1 chk("R10 disable same cycle", '0, 1'b0);
        ee_i = 1'b1;
        #1;
        ack_one();
        chk("R8 wdt cleared only", B_DEC, 1'b1);
        drain();
    endtask

    task automatic t_sticky();
        ee_i = 1'b1;
        pulse(B_FIT);
        chk("R7 set next cycle", B_FIT, 1'b1);
        step(); step(); step();
        chk("R7 held", B_FIT, 1'b1);
        pulse(B_EXT);
        chk("R5 ext over fit", B_EXT, 1'b1);
        drain();
    endtask

    task automatic t_set_wins();
        ee_i = 1'b1;
        pulse(B_EXT);
        req_i = B_EXT;
        ack_i = 1'b1;
        step();
        req_i = '0;
        ack_i = 1'b0;
        chk("R9 set beats clear", B_EXT, 1'b1);
        ack_one();
        chk("R8 then cleared", '0, 1'b0);
    endtask

    task automatic t_ack_masked();
        ee_i = 1'b0;
        pulse(B_DEC);
        chk("R4 dec masked", '0, 1'b0);
        ack_one();
        ee_i = 1'b1;
        #1 chk("R8 masked ack ignored", B_DEC, 1'b1);
        drain();
    endtask

    initial begin
        t_reset();
        t_idle();
        t_full_order();
        t_mck_gating();
        t_sticky();
        t_set_wins();
        t_ack_masked();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule